// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Channel

This block is a single timer channel that produces a pulse-width-modulated output and an interrupt pulse. A 16-bit active counter counts down by one on each tick. The tick comes from one of two sources. The first is the core clock, divided by an 8-bit prescaler plus one and then by a power-of-two divider of 2, 4, 8 or 16. The second is an external tick strobe. The output level comes from comparing the live count against an active compare value, and an inverter control can flip it.

Software never writes the active counter or the active comparator directly. It writes a count buffer and a compare buffer. These values move into the active registers in two cases: while the manual-load control bit is held at 1, or when the counter is at zero and auto-reload is enabled. With auto-reload disabled, the channel runs once. It stops at zero and clears its own start bit. A read-only location returns the live count at any time. Software accesses the block through a simple synchronous write port and a combinational read port.

Top module: `pwm_timer_chan`

## Requirements
- R1: Register map. Address 0 holds the tick configuration, with the prescaler in bits 7:0 and the divider code in bits 11:8. Address 1 holds control: bit 0 start, bit 1 manual load, bit 2 invert, bit 3 auto-reload. Address 2 is the count buffer and address 3 the compare buffer. Address 4 returns the live count and ignores writes. Addresses 5 to 7 read as zero. Writable fields read back as written, and unused upper bits read as zero.
- R2: Writing either buffer leaves the live count and the output unchanged until a manual load or an auto-reload takes place.
- R3: While the manual-load bit is 1, every cycle copies both buffers into the active counter and comparator, one cycle after the bit is seen. Counting is held while it is 1, even if start is also 1.
- R4: When divider code bit 2 is 0, one tick occurs every (prescaler+1)·2^(code[1:0]+1) clock cycles, counted from the cycle in which start takes effect. Code bit 3 is ignored.
- R5: When divider code bit 2 is 1, each cycle in which the external tick input is high while the channel runs is one tick.
- R6: A tick decrements a nonzero count by one. The tick that takes the count from 1 to 0 raises the interrupt output for exactly one cycle, together with the count reading 0.
- R7: With auto-reload on, a tick at count 0 loads both buffers into the active registers. If a buffer is written in that same cycle, the reload uses the value held before the write.
- R8: With auto-reload off, reaching zero clears the start bit. The count then stays at 0 and raises no further interrupt, even when more ticks arrive.
- R9: The output is high while the live count is strictly below the active compare value and low otherwise. The invert bit flips it at once.
- R10: Reset clears the configuration, control, both buffers, the live count, the active compare value and the interrupt, and holds the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write address |
| reg_wdata_i | input | 16 | Write data |
| reg_raddr_i | input | 3 | Read address |
| reg_rdata_o | output | 16 | Read data (combinational) |
| ext_tick_i | input | 1 | External tick strobe, used when divider code bit 2 is 1 |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | One-cycle interrupt on reaching zero |

## Verification
A software write to the count buffer can land in the same cycle as an auto-reload tick at zero. The bench provokes this by asserting the external tick and the buffer write on the same clock edge while the count is 0. The scoreboard expects the reload to take the old buffer value and the new value to appear only at the following reload. A second same-cycle case is a control write that meets the self-clearing of start at the end of a one-shot run. That case is judged through the stop property in the checker.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int CNT_W  = 16;
    localparam int PSC_W  = 8;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG     = 3'd0,
        REG_CTRL    = 3'd1,
        REG_CNT_BUF = 3'd2,
        REG_CMP_BUF = 3'd3,
        REG_LIVE    = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PSC_W-1:0] psc;
    } tick_cfg_t;

    typedef struct packed {
        logic reload;
        logic invert;
        logic update;
        logic start;
    } chan_ctrl_t;

    // Number of prescaled pulses per tick for an internal divider code.
    function automatic logic [DIV_W:0] div_span(input logic [1:0] code);
        return (DIV_W+1)'(2) << code;
    endfunction

    // Bit 2 of the divider code selects the external strobe.
    function automatic logic ext_selected(input logic [SEL_W-1:0] s);
        return s[2];
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_timer_pkg::*;
#(
    parameter int P_W = PSC_W,
    parameter int S_W = SEL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [P_W-1:0] psc,
    input  logic [S_W-1:0] sel,
    input  logic           ext_tick,
    output logic           tick,
    output logic           ext_mode
);

    logic [P_W-1:0]   pre_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_hit;
    logic             div_last;
    logic             unused_sel;

    assign unused_sel = sel[S_W-1];
    assign ext_mode   = ext_selected(sel);
    assign pre_hit    = (pre_q == psc);
    assign div_last   = (div_q == DIV_W'(div_span(sel[1:0]) - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (pre_hit) begin
            pre_q <= '0;
            div_q <= div_last ? '0 : div_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_comb begin
        if (!run)
            tick = 1'b0;
        else if (ext_mode)
            tick = ext_tick;
        else
            tick = pre_hit && div_last;
    end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_timer_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int A_W = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [A_W-1:0] waddr,
    input  logic [C_W-1:0] wdata,
    input  logic [A_W-1:0] raddr,
    output logic [C_W-1:0] rdata,
    input  logic [C_W-1:0] live_cnt,
    input  logic           stop_req,
    output tick_cfg_t      cfg,
    output chan_ctrl_t     ctrl,
    output logic [C_W-1:0] cnt_buf,
    output logic [C_W-1:0] cmp_buf
);

    localparam int CFG_W  = $bits(tick_cfg_t);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    logic unused_wdata;
    assign unused_wdata = ^wdata[C_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            ctrl    <= '0;
            cnt_buf <= '0;
            cmp_buf <= '0;
        end else begin
            if (we) begin
                case (reg_addr_e'(waddr))
                    REG_CFG:     cfg     <= tick_cfg_t'(wdata[CFG_W-1:0]);
                    REG_CTRL:    ctrl    <= chan_ctrl_t'(wdata[CTRL_W-1:0]);
                    REG_CNT_BUF: cnt_buf <= wdata;
                    REG_CMP_BUF: cmp_buf <= wdata;
                    default:     ;
                endcase
            end
            // End of a one-shot run wins over a same-cycle control write.
            if (stop_req)
                ctrl.start <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr_e'(raddr))
            REG_CFG:     rdata = C_W'(cfg);
            REG_CTRL:    rdata = C_W'(ctrl);
            REG_CNT_BUF: rdata = cnt_buf;
            REG_CMP_BUF: rdata = cmp_buf;
            REG_LIVE:    rdata = live_cnt;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_counter_core.sv
module pwm_counter_core
    import pwm_timer_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           load,
    input  logic           reload_en,
    input  logic           invert,
    input  logic [C_W-1:0] cnt_buf,
    input  logic [C_W-1:0] cmp_buf,
    output logic [C_W-1:0] cnt,
    output logic [C_W-1:0] cmp,
    output logic           pwm,
    output logic           irq,
    output logic           stop_req
);

    localparam logic [C_W-1:0] ONE = C_W'(1);

    logic at_zero;
    logic at_one;

    assign at_zero  = (cnt == '0);
    assign at_one   = (cnt == ONE);
    assign stop_req = tick && !load && !reload_en && (at_zero || at_one);
    assign pwm      = invert ^ (cnt < cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            cmp <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                cnt <= cnt_buf;
                cmp <= cmp_buf;
            end else if (tick) begin
                if (at_zero) begin
                    if (reload_en) begin
                        cnt <= cnt_buf;
                        cmp <= cmp_buf;
                    end
                end else begin
                    cnt <= cnt - ONE;
                    irq <= at_one;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int A_W = ADDR_W
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           reg_we_i,
    input  logic [A_W-1:0] reg_waddr_i,
    input  logic [C_W-1:0] reg_wdata_i,
    input  logic [A_W-1:0] reg_raddr_i,
    output logic [C_W-1:0] reg_rdata_o,
    input  logic           ext_tick_i,
    output logic           pwm_o,
    output logic           irq_o
);

    tick_cfg_t      cfg_w;
    chan_ctrl_t     ctrl_w;
    logic [C_W-1:0] cnt_buf_w;
    logic [C_W-1:0] cmp_buf_w;
    logic [C_W-1:0] cnt_w;
    logic [C_W-1:0] cmp_w;
    logic           stop_w;
    logic           run_w;
    logic           tick_w;
    logic           ext_mode_w;

    // Manual load holds the counter even when start is set.
    assign run_w = ctrl_w.start && !ctrl_w.update;

    pwm_chan_regs #(.C_W(C_W), .A_W(A_W)) u_regs (
        .clk      (clk_i),
        .rst      (rst_i),
        .we       (reg_we_i),
        .waddr    (reg_waddr_i),
        .wdata    (reg_wdata_i),
        .raddr    (reg_raddr_i),
        .rdata    (reg_rdata_o),
        .live_cnt (cnt_w),
        .stop_req (stop_w),
        .cfg      (cfg_w),
        .ctrl     (ctrl_w),
        .cnt_buf  (cnt_buf_w),
        .cmp_buf  (cmp_buf_w)
    );

    pwm_tick_gen #(.P_W(PSC_W), .S_W(SEL_W)) u_tick (
        .clk      (clk_i),
        .rst      (rst_i),
        .run      (run_w),
        .psc      (cfg_w.psc),
        .sel      (cfg_w.sel),
        .ext_tick (ext_tick_i),
        .tick     (tick_w),
        .ext_mode (ext_mode_w)
    );

    pwm_counter_core #(.C_W(C_W)) u_core (
        .clk       (clk_i),
        .rst       (rst_i),
        .tick      (tick_w),
        .load      (ctrl_w.update),
        .reload_en (ctrl_w.reload),
        .invert    (ctrl_w.invert),
        .cnt_buf   (cnt_buf_w),
        .cmp_buf   (cmp_buf_w),
        .cnt       (cnt_w),
        .cmp       (cmp_w),
        .pwm       (pwm_o),
        .irq       (irq_o),
        .stop_req  (stop_w)
    );

endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
    parameter int C_W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           irq,
    input logic           pwm,
    input logic [C_W-1:0] cnt,
    input logic [C_W-1:0] cmp,
    input logic [C_W-1:0] cbuf,
    input logic           upd,
    input logic           start,
    input logic           ar,
    input logic           inv,
    input logic           tick,
    input logic           ext_mode
);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == '0));

    assert_manual_load_R3: assert property (@(posedge clk) disable iff (rst)
        $past(upd) |-> (cnt == $past(cbuf)));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(upd) && (cnt != $past(cnt))) |->
            (($past(cnt) != '0 && cnt == $past(cnt) - C_W'(1)) ||
             ($past(cnt) == '0 && $past(ar) && cnt == $past(cbuf))));

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(ar)) |-> !start);

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !ext_mode) |=> (!tick || ext_mode));

    assert_pwm_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && cmp == '0) |-> (pwm == inv));

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.C_W(C_W)) u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .irq      (irq_o),
    .pwm      (pwm_o),
    .cnt      (cnt_w),
    .cmp      (cmp_w),
    .cbuf     (cnt_buf_w),
    .upd      (ctrl_w.update),
    .start    (ctrl_w.start),
    .ar       (ctrl_w.reload),
    .inv      (ctrl_w.invert),
    .tick     (tick_w),
    .ext_mode (ext_mode_w)
);

// File: tb/pwm_timer_chan_bench.sv
`timescale 1ns/1ps
module pwm_timer_chan_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic [2:0]  raddr = '0;
    logic [15:0] rdata;
    logic        ext_tick = 1'b0;
    logic        pwm;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] cnt;
        logic        pwm;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    pwm_timer_chan u_pwm_timer_chan (
        .clk_i       (clk),
        .rst_i       (rst),
        .reg_we_i    (we),
        .reg_waddr_i (waddr),
        .reg_wdata_i (wdata),
        .reg_raddr_i (raddr),
        .reg_rdata_o (rdata),
        .ext_tick_i  (ext_tick),
        .pwm_o       (pwm),
        .irq_o       (irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        raddr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    // Driver: drives one cycle of stimulus and queues the expected result.
    task automatic drive(input bit t, input logic [15:0] c, input bit p, input bit i,
                         input string tag, input bit w = 1'b0,
                         input logic [2:0] a = 3'd0, input logic [15:0] d = 16'd0);
        exp_t e;
        @(negedge clk);
        raddr = 3'd4;
        ext_tick = t;
        we = w; waddr = a; wdata = d;
        e.cnt = c; e.pwm = p; e.irq = i; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        @(negedge clk);
        ext_tick = 1'b0;
        we = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares the outputs just after each edge with the queued item.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(rdata, e.cnt, {e.tag, " count"});
            chk({15'd0, pwm}, {15'd0, e.pwm}, {e.tag, " pwm"});
            chk({15'd0, irq}, {15'd0, e.irq}, {e.tag, " irq"});
        end
    end

    task automatic time_irq(input int exp, input string tag);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 600);
        chk(16'(n), 16'(exp), tag);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 16'h0, "R10 reset register");
        chk({15'd0, pwm}, 16'd0, "R10 reset pwm");
        chk({15'd0, irq}, 16'd0, "R10 reset irq");

        // R1 map and read-back
        wr(3'd0, 16'h0A12);
        rd_chk(3'd0, 16'h0A12, "R1 cfg readback");
        wr(3'd1, 16'hFFF4);
        rd_chk(3'd1, 16'h0004, "R1 ctrl readback");
        wr(3'd1, 16'h0000);
        rd_chk(3'd5, 16'h0000, "R1 unused address");
        wr(3'd0, 16'h0400);

        // R2 buffers are not live yet
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd2);
        rd_chk(3'd2, 16'd5, "R1 count buffer");
        rd_chk(3'd3, 16'd2, "R1 compare buffer");
        rd_chk(3'd4, 16'd0, "R2 live count before load");
        chk({15'd0, pwm}, 16'd0, "R2 pwm before load");

        // R3 manual load, then hold with start set
        wr(3'd1, 16'h0002);
        @(negedge clk);
        rd_chk(3'd4, 16'd5, "R3 manual load");
        wr(3'd1, 16'h000B);
        drive(1, 5, 0, 0, "R3 hold");
        drive(1, 5, 0, 0, "R3 hold");
        drive(1, 5, 0, 0, "R3 hold");
        drain();

        // R5/R6/R9 external ticks with auto-reload
        wr(3'd1, 16'h0009);
        drive(1, 4, 0, 0, "R5 tick");
        drive(1, 3, 0, 0, "R6 dec");
        drive(1, 2, 0, 0, "R9 equal is low");
        drive(1, 1, 1, 0, "R9 below");
        drive(1, 0, 1, 1, "R6 zero irq");
        drive(0, 0, 1, 0, "R6 irq one cycle");
        drive(1, 5, 0, 0, "R7 reload");
        drive(1, 4, 0, 0, "R6 dec");
        drive(1, 3, 0, 0, "R6 dec");
        drive(1, 2, 0, 0, "R6 dec");
        drive(1, 1, 1, 0, "R6 dec");
        drive(1, 0, 1, 1, "R6 zero irq");
        drive(1, 5, 0, 0, "R7 collision old value", 1'b1, 3'd2, 16'd7);
        drive(1, 4, 0, 0, "R7 dec");
        drive(1, 3, 0, 0, "R7 dec");
        drive(1, 2, 0, 0, "R7 dec");
        drive(1, 1, 1, 0, "R7 dec");
        drive(1, 0, 1, 1, "R7 zero irq");
        drive(1, 7, 0, 0, "R7 new value");
        drive(0, 7, 0, 0, "R5 no strobe");
        drain();

        // R9 inverter acts immediately
        wr(3'd1, 16'h000D);
        #1 chk({15'd0, pwm}, 16'd1, "R9 inverted");
        wr(3'd1, 16'h0009);
        #1 chk({15'd0, pwm}, 16'd0, "R9 not inverted");

        // R8 one-shot
        wr(3'd1, 16'h0002);
        wr(3'd1, 16'h0001);
        drive(1, 6, 0, 0, "R8 dec");
        drive(1, 5, 0, 0, "R8 dec");
        drive(1, 4, 0, 0, "R8 dec");
        drive(1, 3, 0, 0, "R8 dec");
        drive(1, 2, 0, 0, "R8 dec");
        drive(1, 1, 1, 0, "R8 dec");
        drive(1, 0, 1, 1, "R8 zero irq");
        drive(1, 0, 1, 0, "R8 stays zero");
        drive(1, 0, 1, 0, "R8 stays zero");
        drain();
        rd_chk(3'd1, 16'h0000, "R8 start cleared");

        // R1 live count ignores writes
        wr(3'd4, 16'h1234);
        rd_chk(3'd4, 16'd0, "R1 live write ignored");

        // R4 internal tick rates
        wr(3'd2, 16'd3);
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'h0002);
        wr(3'd1, 16'h0001);
        time_irq(18, "R4 psc2 div2");
        wr(3'd2, 16'd2);
        wr(3'd0, 16'h0B00);
        wr(3'd1, 16'h0002);
        wr(3'd1, 16'h0001);
        time_irq(32, "R4 psc0 div16 bit3 ignored");
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h0101);
        wr(3'd1, 16'h0002);
        wr(3'd1, 16'h0001);
        time_irq(8, "R4 psc1 div4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule